// File: doc/BRIEF.md
# Tone Cadence Classifier

The classifier sits behind a bank of five tone-detect flags (one per progress-tone frequency: 350, 440, 480, 620 and 425 Hz) and names the state of a telephone line. Two things are combined. The first is which frequencies are present together. The second is how the tone is timed: its on and off periods, counted in ticks of a one-millisecond strobe. Tones that share a frequency pair are told apart by their cadence. Busy and reorder both use the 480 + 620 Hz pair and differ only in their interruption rate.

The result is a 4-bit class code. It holds its value and is marked by a one-clock valid pulse each time it changes. A dialed-digit event ends a dial-tone classification. If no pattern is found within a fixed window after the line first becomes active, the code becomes "unknown". All durations are parameters, expressed in ticks.

Top module: `tone_cadence_classifier`

## Requirements
- R1: While `rstN` is low and after it rises, `classCode` is 0 (idle) and `classValid` is 0 until a pattern is found.
- R2: `toneFlags` uses bit0 = 350 Hz, bit1 = 440 Hz, bit2 = 480 Hz, bit3 = 620 Hz and bit4 = 425 Hz. Exactly bits 0 and 1 present, without a break for 1000 ticks, gives dial tone (code 1). The code appears one clock after the 1000th tick and not earlier.
- R3: A `digitEvt` pulse while the code is dial returns the code to idle (0) in the next clock. Dial tone cannot be reported again until the flags have been all zero on at least one tick.
- R4: Exactly bits 2 and 3 (480 + 620 Hz), interrupted with on and off periods of 500 ticks, give busy (code 2). The code is reported at the rise that completes the second consecutive matching on/off cycle.
- R5: The same pair interrupted at 250 ticks on and 250 ticks off gives reorder (code 3), also after two consecutive matching cycles. A busy cycle followed by a reorder cycle resets the count.
- R6: A measured period is accepted when it lies within the nominal value plus or minus 20 percent, bounds included (busy: 400 to 600 ticks). A period of 399 ticks is rejected.
- R7: Exactly bits 1 and 2 (440 + 480 Hz), with one complete cycle of 2000 ticks on (1600 to 2400) and 4000 ticks off (3200 to 4800), give audible ring (code 4) at the next rise.
- R8: A single tone held without a break for 1000 ticks gives a class after the 1000th tick: bit4 alone gives European tone (code 5), bit1 alone gives alert (code 6), and bit2 alone gives high tone (code 7). The cadence pairs (480 + 620 and 440 + 480) are never classified as steady tones.
- R9: If the code is still idle 8000 ticks after the first tick with any flag set, the code becomes unknown (code 8) one clock later.
- R10: `classValid` is high for exactly the one clock in which `classCode` takes a new value and is low otherwise. A `digitEvt` pulse while the code is not dial changes nothing.
- R11: Time advances only on clocks where `msTick` is high. With `msTick` low, flags held for any number of clocks produce no class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | One-clock strobe marking each millisecond |
| toneFlags | input | 5 | Qualified detect flags: bit0 350 Hz, bit1 440 Hz, bit2 480 Hz, bit3 620 Hz, bit4 425 Hz |
| digitEvt | input | 1 | One-clock pulse when a dialed digit is received |
| classCode | output | 4 | Line class: 0 idle, 1 dial, 2 busy, 3 reorder, 4 ring, 5 European, 6 alert, 7 high, 8 unknown |
| classValid | output | 1 | One-clock pulse when `classCode` changes |

## Verification
The bound assertions check the following on every cycle:
- the valid pulse coincides exactly with a change of code;
- unknown can only be reached from idle;
- a return to idle is always caused by a digit during dial tone;
- a cadence class (busy, reorder, ring) only appears just after a tick that saw tone on the line.

The directed scenarios are the only place where the following are shown:
- the thresholds themselves: the exact clock at which dial or unknown appears, and the inclusive tolerance bounds;
- the two-cycle rule that separates busy from reorder;
- the suppression of dial tone after a digit until the line has gone silent;
- the freezing of time while `msTick` is low.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  localparam int unsigned TONE_N = 5;

  // Flag bit positions shared by every module and the bench.
  localparam int unsigned B350 = 0;
  localparam int unsigned B440 = 1;
  localparam int unsigned B480 = 2;
  localparam int unsigned B620 = 3;
  localparam int unsigned B425 = 4;

  localparam logic [TONE_N-1:0] M_NONE  = '0;
  localparam logic [TONE_N-1:0] M_DIAL  = (TONE_N'(1) << B350) | (TONE_N'(1) << B440);
  localparam logic [TONE_N-1:0] M_RING  = (TONE_N'(1) << B440) | (TONE_N'(1) << B480);
  localparam logic [TONE_N-1:0] M_BUSY  = (TONE_N'(1) << B480) | (TONE_N'(1) << B620);
  localparam logic [TONE_N-1:0] M_EURO  = TONE_N'(1) << B425;
  localparam logic [TONE_N-1:0] M_ALERT = TONE_N'(1) << B440;
  localparam logic [TONE_N-1:0] M_HIGH  = TONE_N'(1) << B480;

  typedef enum logic [2:0] {
    PAIR_NONE, PAIR_DIAL, PAIR_RING, PAIR_BUSY,
    PAIR_EURO, PAIR_ALERT, PAIR_HIGH, PAIR_OTHER
  } pair_e;

  typedef enum logic [3:0] {
    CLS_IDLE    = 4'd0,
    CLS_DIAL    = 4'd1,
    CLS_BUSY    = 4'd2,
    CLS_REORDER = 4'd3,
    CLS_RING    = 4'd4,
    CLS_EURO    = 4'd5,
    CLS_ALERT   = 4'd6,
    CLS_HIGH    = 4'd7,
    CLS_UNKNOWN = 4'd8
  } class_e;

  // Strobes from the decision logic to the timing datapath.
  typedef struct packed {
    logic winStop;   // a pattern was found: stop the search window
    logic winRearm;  // dial tone ended by a digit: allow a new window
  } strobe_t;

  function automatic pair_e decodePair(input logic [TONE_N-1:0] f);
    pair_e p;
    case (f)
      M_NONE:  p = PAIR_NONE;
      M_DIAL:  p = PAIR_DIAL;
      M_RING:  p = PAIR_RING;
      M_BUSY:  p = PAIR_BUSY;
      M_EURO:  p = PAIR_EURO;
      M_ALERT: p = PAIR_ALERT;
      M_HIGH:  p = PAIR_HIGH;
      default: p = PAIR_OTHER;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/tcc_period_path.sv
module tcc_period_path
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned WINDOW_MS = 8000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                msTick,
  input  logic [TONE_N-1:0]   toneFlags,
  input  strobe_t             strobe,
  output logic                lineOn,
  output logic                riseEvt,
  output pair_e               runPair,
  output logic [CNT_W-1:0]    onCnt,
  output pair_e               heldPair,
  output logic [CNT_W-1:0]    heldOnLen,
  output logic [CNT_W-1:0]    offCnt,
  output logic                winExpired
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] WIN_LIM = CNT_W'(WINDOW_MS);

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_TOP) ? v : v + 1'b1;
  endfunction

  pair_e pairNow;
  logic  toneNow;
  logic  winRun;
  logic  winArmed;
  logic [CNT_W-1:0] winCnt;

  assign pairNow    = decodePair(toneFlags);
  assign toneNow    = |toneFlags;
  assign riseEvt    = msTick && toneNow && !lineOn;
  assign winExpired = winRun && (winCnt >= WIN_LIM);

  // On/off period measurement, sampled once per tick.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineOn    <= 1'b0;
      runPair   <= PAIR_NONE;
      onCnt     <= '0;
      heldPair  <= PAIR_NONE;
      heldOnLen <= '0;
      offCnt    <= '0;
    end else if (msTick) begin
      lineOn <= toneNow;
      if (toneNow && !lineOn) begin
        onCnt   <= CNT_W'(1);
        runPair <= pairNow;
      end else if (toneNow) begin
        onCnt <= satInc(onCnt);
        if (pairNow != runPair) runPair <= PAIR_OTHER;
      end else if (lineOn) begin
        heldOnLen <= onCnt;
        heldPair  <= runPair;
        offCnt    <= CNT_W'(1);
        onCnt     <= '0;
        runPair   <= PAIR_NONE;
      end else begin
        offCnt <= satInc(offCnt);
      end
    end
  end

  // Search window opened by the first active tick.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winRun   <= 1'b0;
      winArmed <= 1'b1;
      winCnt   <= '0;
    end else if (strobe.winRearm) begin
      winRun   <= 1'b0;
      winArmed <= 1'b1;
      winCnt   <= '0;
    end else if (strobe.winStop || winExpired) begin
      winRun <= 1'b0;
    end else if (msTick) begin
      if (winRun) begin
        winCnt <= satInc(winCnt);
      end else if (winArmed && toneNow) begin
        winRun   <= 1'b1;
        winArmed <= 1'b0;
        winCnt   <= CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/tcc_tol_window.sv
module tcc_tol_window #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NOM_MS  = 500,
  parameter int unsigned TOL_DIV = 5
) (
  input  logic [CNT_W-1:0] value,
  output logic             hit
);

  localparam int unsigned LO = NOM_MS - NOM_MS / TOL_DIV;
  localparam int unsigned HI = NOM_MS + NOM_MS / TOL_DIV;

  assign hit = (value >= CNT_W'(LO)) && (value <= CNT_W'(HI));

endmodule

// File: rtl/tcc_decide.sv
module tcc_decide
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W           = 16,
  parameter int unsigned STEADY_MS       = 1000,
  parameter int unsigned BUSY_HALF_MS    = 500,
  parameter int unsigned REORDER_HALF_MS = 250,
  parameter int unsigned RING_ON_MS      = 2000,
  parameter int unsigned RING_OFF_MS     = 4000,
  parameter int unsigned TOL_DIV         = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             digitEvt,
  input  logic             lineOn,
  input  logic             riseEvt,
  input  pair_e            runPair,
  input  logic [CNT_W-1:0] onCnt,
  input  pair_e            heldPair,
  input  logic [CNT_W-1:0] heldOnLen,
  input  logic [CNT_W-1:0] offCnt,
  input  logic             winExpired,
  output strobe_t          strobe,
  output class_e           classReg,
  output logic             validReg
);

  localparam int unsigned N_WIN = 6;
  // Even entries judge the on period, odd entries the off period.
  localparam int unsigned WIN_NOM [N_WIN] = '{
    BUSY_HALF_MS, BUSY_HALF_MS, REORDER_HALF_MS, REORDER_HALF_MS,
    RING_ON_MS, RING_OFF_MS
  };
  localparam logic [CNT_W-1:0] STEADY_LIM = CNT_W'(STEADY_MS);

  logic [N_WIN-1:0] winHit;

  for (genvar g = 0; g < N_WIN; g++) begin : g_tol
    tcc_tol_window #(
      .CNT_W  (CNT_W),
      .NOM_MS (WIN_NOM[g]),
      .TOL_DIV(TOL_DIV)
    ) u_win (
      .value((g % 2 == 0) ? heldOnLen : offCnt),
      .hit  (winHit[g])
    );
  end

  logic   busyOk, reorderOk, ringOk;
  logic   busySeen, reorderSeen, dialInhibit;
  class_e steadyCls;
  class_e nextCls;

  assign busyOk    = (heldPair == PAIR_BUSY) && winHit[0] && winHit[1];
  assign reorderOk = (heldPair == PAIR_BUSY) && winHit[2] && winHit[3];
  assign ringOk    = (heldPair == PAIR_RING) && winHit[4] && winHit[5];

  always_comb begin
    steadyCls = CLS_IDLE;
    if (lineOn && (onCnt >= STEADY_LIM)) begin
      case (runPair)
        PAIR_DIAL:  steadyCls = dialInhibit ? CLS_IDLE : CLS_DIAL;
        PAIR_EURO:  steadyCls = CLS_EURO;
        PAIR_ALERT: steadyCls = CLS_ALERT;
        PAIR_HIGH:  steadyCls = CLS_HIGH;
        default:    steadyCls = CLS_IDLE;
      endcase
    end
  end

  // Priority: digit, then cadence matches, then steady tones, then timeout.
  always_comb begin
    nextCls         = classReg;
    strobe.winStop  = 1'b0;
    strobe.winRearm = 1'b0;
    if (digitEvt && (classReg == CLS_DIAL)) begin
      nextCls         = CLS_IDLE;
      strobe.winRearm = 1'b1;
    end else if (riseEvt && busyOk && busySeen) begin
      nextCls        = CLS_BUSY;
      strobe.winStop = 1'b1;
    end else if (riseEvt && reorderOk && reorderSeen) begin
      nextCls        = CLS_REORDER;
      strobe.winStop = 1'b1;
    end else if (riseEvt && ringOk) begin
      nextCls        = CLS_RING;
      strobe.winStop = 1'b1;
    end else if (steadyCls != CLS_IDLE) begin
      nextCls        = steadyCls;
      strobe.winStop = 1'b1;
    end else if (winExpired && (classReg == CLS_IDLE)) begin
      nextCls = CLS_UNKNOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      classReg    <= CLS_IDLE;
      validReg    <= 1'b0;
      busySeen    <= 1'b0;
      reorderSeen <= 1'b0;
      dialInhibit <= 1'b0;
    end else begin
      classReg <= nextCls;
      validReg <= (nextCls != classReg);
      if (riseEvt) begin
        busySeen    <= busyOk;
        reorderSeen <= reorderOk;
      end
      if (digitEvt)     dialInhibit <= 1'b1;
      else if (!lineOn) dialInhibit <= 1'b0;
    end
  end

endmodule

// File: rtl/tone_cadence_classifier.sv
module tone_cadence_classifier
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W           = 16,
  parameter int unsigned STEADY_MS       = 1000,
  parameter int unsigned WINDOW_MS       = 8000,
  parameter int unsigned BUSY_HALF_MS    = 500,
  parameter int unsigned REORDER_HALF_MS = 250,
  parameter int unsigned RING_ON_MS      = 2000,
  parameter int unsigned RING_OFF_MS     = 4000,
  parameter int unsigned TOL_DIV         = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msTick,
  input  logic [TONE_N-1:0] toneFlags,
  input  logic              digitEvt,
  output logic [3:0]        classCode,
  output logic              classValid
);

  strobe_t          strobe;
  logic             lineOn, riseEvt, winExpired;
  pair_e            runPair, heldPair;
  logic [CNT_W-1:0] onCnt, heldOnLen, offCnt;
  class_e           classReg;

  tcc_period_path #(
    .CNT_W    (CNT_W),
    .WINDOW_MS(WINDOW_MS)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .msTick    (msTick),
    .toneFlags (toneFlags),
    .strobe    (strobe),
    .lineOn    (lineOn),
    .riseEvt   (riseEvt),
    .runPair   (runPair),
    .onCnt     (onCnt),
    .heldPair  (heldPair),
    .heldOnLen (heldOnLen),
    .offCnt    (offCnt),
    .winExpired(winExpired)
  );

  tcc_decide #(
    .CNT_W          (CNT_W),
    .STEADY_MS      (STEADY_MS),
    .BUSY_HALF_MS   (BUSY_HALF_MS),
    .REORDER_HALF_MS(REORDER_HALF_MS),
    .RING_ON_MS     (RING_ON_MS),
    .RING_OFF_MS    (RING_OFF_MS),
    .TOL_DIV        (TOL_DIV)
  ) u_decide (
    .clk       (clk),
    .rstN      (rstN),
    .digitEvt  (digitEvt),
    .lineOn    (lineOn),
    .riseEvt   (riseEvt),
    .runPair   (runPair),
    .onCnt     (onCnt),
    .heldPair  (heldPair),
    .heldOnLen (heldOnLen),
    .offCnt    (offCnt),
    .winExpired(winExpired),
    .strobe    (strobe),
    .classReg  (classReg),
    .validReg  (classValid)
  );

  assign classCode = classReg;

endmodule

// File: rtl/tcc_checker.sv
module tcc_checker
  import tcc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              msTick,
  input logic [TONE_N-1:0] toneFlags,
  input logic              digitEvt,
  input logic [3:0]        classCode,
  input logic              classValid
);

  assert_code_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    classCode <= CLS_UNKNOWN);

  assert_valid_iff_change_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (classValid == (classCode != $past(classCode))));

  assert_unknown_from_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (classValid && classCode == CLS_UNKNOWN) |-> ($past(classCode) == CLS_IDLE));

  assert_idle_by_digit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (classValid && classCode == CLS_IDLE)
      |-> ($past(digitEvt) && $past(classCode) == CLS_DIAL));

  assert_cadence_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (classValid && (classCode inside {CLS_BUSY, CLS_REORDER, CLS_RING}))
      |-> ($past(msTick) && ($past(toneFlags) != '0)));

endmodule

bind tone_cadence_classifier tcc_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .msTick    (msTick),
  .toneFlags (toneFlags),
  .digitEvt  (digitEvt),
  .classCode (classCode),
  .classValid(classValid)
);

// File: tb/tone_cadence_classifier_test.sv
`timescale 1ns/1ps
module tone_cadence_classifier_test;

  localparam logic [4:0] F350 = 5'b00001;
  localparam logic [4:0] F440 = 5'b00010;
  localparam logic [4:0] F480 = 5'b00100;
  localparam logic [4:0] F620 = 5'b01000;
  localparam logic [4:0] F425 = 5'b10000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       msTick = 1'b0;
  logic [4:0] toneFlags = '0;
  logic       digitEvt = 1'b0;
  logic [3:0] classCode;
  logic       classValid;

  logic tickEn = 1'b1;
  logic tickHalf = 1'b0;
  int   total = 0;
  int   bad = 0;
  int   validCnt = 0;

  tone_cadence_classifier uut (
    .clk       (clk),
    .rstN      (rstN),
    .msTick    (msTick),
    .toneFlags (toneFlags),
    .digitEvt  (digitEvt),
    .classCode (classCode),
    .classValid(classValid)
  );

  always #4 clk = ~clk;

  always @(negedge clk) msTick <= tickEn && !(tickHalf && msTick);

  always @(posedge clk) if (rstN && classValid) validCnt <= validCnt + 1;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkCode(input string req, input int exp);
    checkVal(req, "classCode", int'(classCode), exp);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; toneFlags = '0; digitEvt = 1'b0; tickEn = 1'b1; tickHalf = 1'b0;
    step(3);
    checkCode("R1", 0);
    checkVal("R1", "classValid in reset", int'(classValid), 0);
    rstN = 1'b1;
    validCnt = 0;
  endtask

  task automatic cycle(input logic [4:0] f, input int onT, input int offT);
    toneFlags = f;  step(onT);
    toneFlags = '0; step(offT);
  endtask

  task automatic testReset();
    doReset();
    step(5);
    checkCode("R1", 0);
    checkVal("R1", "classValid idle", int'(classValid), 0);
  endtask

  task automatic testDial();
    doReset();
    toneFlags = F350 | F440;
    step(1000);
    checkCode("R2", 0);
    step(1);
    checkCode("R2", 1);
    checkVal("R10", "valid on dial", int'(classValid), 1);
    step(1);
    checkVal("R10", "valid one clock", int'(classValid), 0);
    digitEvt = 1'b1; step(1); digitEvt = 1'b0;
    checkCode("R3", 0);
    checkVal("R3", "valid on digit", int'(classValid), 1);
    step(2000);
    checkCode("R3", 0);
    toneFlags = '0; step(10);
    toneFlags = F350 | F440; step(1001);
    checkCode("R3", 1);
    step(1);
    checkVal("R10", "valid count dial", validCnt, 3);
  endtask

  task automatic testCadence(input string req, input logic [4:0] f,
                             input int onT, input int offT, input int exp);
    doReset();
    cycle(f, onT, offT);
    cycle(f, onT, offT);
    checkCode(req, 0);
    toneFlags = f; step(1);
    checkCode(req, exp);
    step(1);
    checkVal("R10", "valid count cadence", validCnt, (exp == 0) ? 0 : 1);
  endtask

  task automatic testMixed();
    doReset();
    cycle(F480 | F620, 500, 500);
    cycle(F480 | F620, 250, 250);
    cycle(F480 | F620, 500, 500);
    toneFlags = F480 | F620; step(2);
    checkCode("R5", 0);
  endtask

  task automatic testRing();
    doReset();
    cycle(F440 | F480, 2000, 4000);
    checkCode("R7", 0);
    toneFlags = F440 | F480; step(1);
    checkCode("R7", 4);
    checkVal("R10", "valid on ring", int'(classValid), 1);
  endtask

  task automatic testSingle(input logic [4:0] f, input int exp);
    doReset();
    toneFlags = f; step(1000);
    checkCode("R8", 0);
    step(1);
    checkCode("R8", exp);
  endtask

  task automatic testDigitIgnored();
    testSingle(F425, 5);
    step(2);
    digitEvt = 1'b1; step(1); digitEvt = 1'b0;
    checkCode("R10", 5);
    checkVal("R10", "valid after ignored digit", int'(classValid), 0);
    step(2);
    checkVal("R10", "valid count euro", validCnt, 1);
  endtask

  task automatic testUnknown();
    doReset();
    toneFlags = F480 | F620; step(2000);
    checkCode("R8", 0);
    toneFlags = F350; step(6000);
    checkCode("R9", 0);
    step(1);
    checkCode("R9", 8);
    checkVal("R9", "valid on unknown", int'(classValid), 1);
  endtask

  task automatic testTickGate();
    doReset();
    tickEn = 1'b0; step(2);
    toneFlags = F350 | F440; step(3000);
    checkCode("R11", 0);
    tickHalf = 1'b1; tickEn = 1'b1;
    step(1990);
    checkCode("R11", 0);
    step(30);
    checkCode("R11", 1);
  endtask

  initial begin
    testReset();
    testDial();
    testCadence("R4", F480 | F620, 500, 500, 2);
    testCadence("R5", F480 | F620, 250, 250, 3);
    testCadence("R6", F480 | F620, 400, 600, 2);
    testCadence("R6", F480 | F620, 399, 500, 0);
    testCadence("R6", F480 | F620, 500, 601, 0);
    testMixed();
    testRing();
    testSingle(F440, 6);
    testSingle(F480, 7);
    testDigitIgnored();
    testUnknown();
    testTickGate();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule